// File: doc/BRIEF.md
# Shared Multi-Port Memory with Same-Address Conflict Policies

This block is a small synchronous word store that several processor ports reach in the same clock cycle. On each port a request carries a valid strobe, a direction flag, a word address and write data. Every cycle the block compares the addresses of all active requests. It then decides, under a run-time mode, which reads are legal, which writes are legal and which single value reaches a location that several ports target together.

Five policies can be chosen. In the first, both reads and writes to one address must be unique. In the second, reads may be shared but writes must be unique. In the other three, both may be shared, and colliding writes are settled in one of three ways: all writers must agree on one value, a rotating choice picks the stored value, or the lowest port index wins. Each port gets its read word, an error flag and a grant flag, all registered, one cycle after its request.

Top module: `shmem_resolve`

## Requirements
- R1: While reset is low and in the first cycle after it, portRdata, portErr and portGrant are all zero. Reset clears every word of the memory to zero.
- R2: Results are registered. The cycle after a request, portRdata shows the word held before that cycle's writes, so a read that collides with a write to the same address returns the old contents. A stored write can be read from the following cycle on.
- R3: In mode 0, when two or more valid read ports use the same address in one cycle, each of those readers gets portErr=1. Each still receives the stored word.
- R4: In modes 0 and 1, when two or more valid write ports use the same address in one cycle, each of those writers gets portErr=1 and portGrant=0, and the word stays unchanged. A lone writer to an address gets portGrant=1 and portErr=0, and its data is stored.
- R5: In modes 1, 2, 3 and 4, reads never raise portErr, and every reader of an address receives the stored word.
- R6: In mode 2, writers that share an address and all present one value all get portGrant=1, and that value is stored. When any two of them differ, all of them get portErr=1 and portGrant=0, and the word stays unchanged.
- R7: In mode 4, among writers that share an address, the lowest port index is stored and granted. The other writers get portGrant=0 and portErr=0.
- R8: In mode 3, a rotating pointer starts at 0 after reset. The pointer advances by one, modulo the port count, after each mode-3 cycle in which some address has two or more writers. The winner among writers sharing an address is the first writer found when scanning port indices upward from the pointer, wrapping around. Only the winner is stored and granted, and no writer gets portErr.
- R9: Mode codes 5, 6 and 7 behave exactly as mode 0.
- R10: Writes to different addresses in one cycle are all stored and all granted, independently of each other.
- R11: A port without a valid request, and a write port, both get portRdata=0. A port without a valid request also gets portErr=0 and portGrant=0, and it does not affect the other ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| mode | input | 3 | Conflict policy, sampled every cycle: 0 exclusive read and write, 1 shared read and exclusive write, 2 agree-on-value writes, 3 rotating-choice writes, 4 lowest-index writes |
| portValid | input | P | Request strobe for each port |
| portWrite | input | P | 1 = write, 0 = read, for each port |
| portAddr | input | P x AW | Word address for each port |
| portWdata | input | P x DW | Write data for each port |
| portRdata | output | P x DW | Registered read word for each port |
| portErr | output | P | Registered conflict error for each port |
| portGrant | output | P | Registered flag, set when this writer's value was the one stored |

## Verification
A read and a write can hit the same address in the same cycle, as can a collision among reads and a collision among writes on a second address. Both cases are driven by sweeping every mix of six per-port actions over two addresses, in all eight mode codes, with a read-back cycle after each pattern. A reference model in the bench applies the read-before-write order and the per-mode winner rules, including the rotating pointer. Returned words, error flags and grant flags are compared with the model every cycle.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  typedef enum logic [2:0] {
    MODE_EXCL_ALL  = 3'd0,
    MODE_EXCL_WR   = 3'd1,
    MODE_CW_AGREE  = 3'd2,
    MODE_CW_ROTATE = 3'd3,
    MODE_CW_LOWEST = 3'd4
  } memMode_e;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic err;
    logic grant;
  } portStrobe_t;

endpackage

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int P  = 4,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            mode,
  input  logic [P-1:0]          portValid,
  input  logic [P-1:0]          portWrite,
  input  logic [P-1:0][AW-1:0]  portAddr,
  input  logic [P-1:0][DW-1:0]  portWdata,
  output portStrobe_t [P-1:0]   strb
);

  localparam int PW = (P > 1) ? $clog2(P) : 1;

  logic [PW-1:0] rotPtr;
  logic          exclRd, exclWr, agreeWr, rotateWr;
  logic [P-1:0]  isRd, isWr, rdClash, wrClash, dataDiff, ahead;

  // Scan order distance of port idx from the start index base.
  function automatic int keyOf(int idx, int base);
    return (idx >= base) ? idx - base : idx + P - base;
  endfunction

  always_comb begin
    agreeWr  = (mode == MODE_CW_AGREE);
    rotateWr = (mode == MODE_CW_ROTATE);
    exclRd   = (mode == MODE_EXCL_ALL) || (mode > MODE_CW_LOWEST);
    exclWr   = exclRd || (mode == MODE_EXCL_WR);
  end

  always_comb begin
    int   base;
    logic sameA;
    logic peer;
    base     = rotateWr ? int'(rotPtr) : 0;
    isRd     = portValid & ~portWrite;
    isWr     = portValid & portWrite;
    rdClash  = '0;
    wrClash  = '0;
    dataDiff = '0;
    ahead    = '0;
    for (int i = 0; i < P; i++) begin
      for (int j = 0; j < P; j++) begin
        if (i != j) begin
          sameA = (portAddr[i] == portAddr[j]);
          peer  = isWr[i] && isWr[j] && sameA;
          if (isRd[i] && isRd[j] && sameA) rdClash[i] = 1'b1;
          if (peer) wrClash[i] = 1'b1;
          if (peer && (portWdata[i] != portWdata[j])) dataDiff[i] = 1'b1;
          if (peer && (keyOf(j, base) < keyOf(i, base))) ahead[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < P; g++) begin : gStrb
    logic errG;
    assign errG = (exclRd && rdClash[g]) || (exclWr && wrClash[g]) ||
                  (agreeWr && dataDiff[g]);
    assign strb[g].rdEn  = isRd[g];
    assign strb[g].err   = errG;
    assign strb[g].wrEn  = isWr[g] && !ahead[g] && !errG;
    assign strb[g].grant = isWr[g] && !errG && (agreeWr || !ahead[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotPtr <= '0;
    end else if (rotateWr && (|wrClash)) begin
      rotPtr <= (rotPtr == PW'(P - 1)) ? '0 : rotPtr + 1'b1;
    end
  end

endmodule

// File: rtl/shmem_dp.sv
module shmem_dp
  import shmem_pkg::*;
#(
  parameter int P     = 4,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  portStrobe_t [P-1:0]   strb,
  input  logic [P-1:0][AW-1:0]  portAddr,
  input  logic [P-1:0][DW-1:0]  portWdata,
  output logic [P-1:0][DW-1:0]  portRdata,
  output logic [P-1:0]          portErr,
  output logic [P-1:0]          portGrant
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) store[k] <= '0;
      portRdata <= '0;
      portErr   <= '0;
      portGrant <= '0;
    end else begin
      for (int i = 0; i < P; i++) begin
        portRdata[i] <= strb[i].rdEn ? store[portAddr[i]] : '0;
        portErr[i]   <= strb[i].err;
        portGrant[i] <= strb[i].grant;
        if (strb[i].wrEn) store[portAddr[i]] <= portWdata[i];
      end
    end
  end

endmodule

// File: rtl/shmem_resolve.sv
module shmem_resolve
  import shmem_pkg::*;
#(
  parameter int  P     = 4,
  parameter int  DEPTH = 16,
  parameter int  DW    = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            mode,
  input  logic [P-1:0]          portValid,
  input  logic [P-1:0]          portWrite,
  input  logic [P-1:0][AW-1:0]  portAddr,
  input  logic [P-1:0][DW-1:0]  portWdata,
  output logic [P-1:0][DW-1:0]  portRdata,
  output logic [P-1:0]          portErr,
  output logic [P-1:0]          portGrant
);

  portStrobe_t [P-1:0] strb;

  shmem_ctrl #(.P(P), .AW(AW), .DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .portValid(portValid), .portWrite(portWrite),
    .portAddr(portAddr), .portWdata(portWdata), .strb(strb)
  );

  shmem_dp #(.P(P), .DEPTH(DEPTH), .AW(AW), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .portAddr(portAddr), .portWdata(portWdata),
    .portRdata(portRdata), .portErr(portErr), .portGrant(portGrant)
  );

endmodule

// File: rtl/shmem_chk.sv
module shmem_chk #(
  parameter int P = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic [2:0]   mode,
  input logic [P-1:0] portValid,
  input logic [P-1:0] portWrite,
  input logic [P-1:0] portErr,
  input logic [P-1:0] portGrant
);

  AST_GRANT_ONLY_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((portGrant & ~$past(portValid & portWrite)) == '0)); // R11

  AST_GRANT_NOT_ERR: assert property (@(posedge clk) disable iff (!rstN)
    ((portGrant & portErr) == '0)); // R4

  AST_NO_ERR_PICK_MODES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (($past(mode) == 3'd3) || ($past(mode) == 3'd4)))
      |-> (portErr == '0)); // R7

  AST_SHARED_READ_OK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(mode) == 3'd1))
      |-> ((portErr & $past(portValid & ~portWrite)) == '0)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(portValid) == '0))
      |-> ((portErr == '0) && (portGrant == '0))); // R11

endmodule

bind shmem_resolve shmem_chk #(.P(P)) chk_i (
  .clk(clk), .rstN(rstN), .mode(mode), .portValid(portValid),
  .portWrite(portWrite), .portErr(portErr), .portGrant(portGrant)
);

// File: tb/shmem_resolve_tb_top.sv
module shmem_resolve_tb_top;

  localparam int P     = 4;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]           mode;
  logic [P-1:0]         portValid, portWrite;
  logic [P-1:0][AW-1:0] portAddr;
  logic [P-1:0][DW-1:0] portWdata, portRdata;
  logic [P-1:0]         portErr, portGrant;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [DEPTH];
  int rrModel;
  logic [DW-1:0] expRd [P];
  logic expErr [P];
  logic expGr [P];

  shmem_resolve #(.P(P), .DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .mode(mode), .portValid(portValid),
    .portWrite(portWrite), .portAddr(portAddr), .portWdata(portWdata),
    .portRdata(portRdata), .portErr(portErr), .portGrant(portGrant)
  );

  task automatic setPort(int i, bit v, bit w, int a, int d);
    portValid[i] = v;
    portWrite[i] = w;
    portAddr[i]  = AW'(a);
    portWdata[i] = DW'(d);
  endtask

  task automatic computeExpect();
    int  m;
    bit  exRd, exWr, collided;
    m = int'(mode);
    exRd = (m == 0) || (m > 4);
    exWr = exRd || (m == 1);
    collided = 1'b0;
    for (int i = 0; i < P; i++) begin
      expErr[i] = 1'b0;
      expGr[i]  = 1'b0;
      expRd[i]  = '0;
      if (portValid[i] && !portWrite[i]) begin
        expRd[i] = model[portAddr[i]];
        if (exRd)
          for (int j = 0; j < P; j++)
            if (j != i && portValid[j] && !portWrite[j] && portAddr[j] == portAddr[i])
              expErr[i] = 1'b1;
      end
    end
    for (int i = 0; i < P; i++) begin
      if (portValid[i] && portWrite[i]) begin
        int cnt, best, bestKey, base;
        bit diff;
        cnt = 0; diff = 1'b0; best = -1; bestKey = P + 1;
        base = (m == 3) ? rrModel : 0;
        for (int j = 0; j < P; j++) begin
          if (portValid[j] && portWrite[j] && portAddr[j] == portAddr[i]) begin
            int key;
            cnt++;
            if (portWdata[j] != portWdata[i]) diff = 1'b1;
            key = (j - base + P) % P;
            if (key < bestKey) begin bestKey = key; best = j; end
          end
        end
        if (cnt > 1) collided = 1'b1;
        if (exWr && cnt > 1) expErr[i] = 1'b1;
        else if (m == 2 && diff) expErr[i] = 1'b1;
        else if (m == 2) expGr[i] = 1'b1;
        else expGr[i] = (best == i);
      end
    end
    for (int i = 0; i < P; i++)
      if (expGr[i]) model[portAddr[i]] = portWdata[i];
    if (m == 3 && collided) rrModel = (rrModel + 1) % P;
  endtask

  // Inputs are set at a falling edge; one rising edge later the results are checked.
  task automatic step(string tag);
    int  m;
    bit  vS [P];
    bit  wS [P];
    m = int'(mode);
    for (int i = 0; i < P; i++) begin vS[i] = portValid[i]; wS[i] = portWrite[i]; end
    computeExpect();
    @(negedge clk);
    for (int i = 0; i < P; i++) begin
      string t;
      t = tag;
      if (t == "") begin
        if (!vS[i]) t = "R11";
        else if (m > 4) t = "R9";
        else if (!wS[i]) t = (m == 0) ? "R3" : "R5";
        else if (m <= 1) t = "R4";
        else if (m == 2) t = "R6";
        else if (m == 3) t = "R8";
        else t = "R7";
      end
      checks++;
      if (portRdata[i] !== expRd[i] || portErr[i] !== expErr[i] || portGrant[i] !== expGr[i]) begin
        failures++;
        $display("FAIL %s port %0d mode %0d: rdata=%h err=%b grant=%b expected rdata=%h err=%b grant=%b",
                 t, i, m, portRdata[i], portErr[i], portGrant[i], expRd[i], expErr[i], expGr[i]);
      end
    end
  endtask

  task automatic readBack(int a0, int a1, int a2, int a3, string tag);
    mode = 3'd1;
    setPort(0, 1, 0, a0, 0);
    setPort(1, 1, 0, a1, 0);
    setPort(2, 1, 0, a2, 0);
    setPort(3, 1, 0, a3, 0);
    step(tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    mode = '0; portValid = '0; portWrite = '0; portAddr = '0; portWdata = '0;
    for (int k = 0; k < DEPTH; k++) model[k] = '0;
    rrModel = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    checks++;
    if (portRdata !== '0 || portErr !== '0 || portGrant !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs: rdata=%h err=%b grant=%b expected 0",
               portRdata, portErr, portGrant);
    end
    rstN = 1'b1;
    readBack(0, 5, 10, 15, "R1");

    // R2: write and read of one address in one cycle returns the old word
    mode = 3'd0;
    setPort(0, 1, 1, 3, 16'h1234);
    setPort(1, 1, 0, 3, 0);
    setPort(2, 0, 0, 0, 0);
    setPort(3, 0, 0, 0, 0);
    step("R2");
    readBack(3, 0, 0, 0, "R2");

    // R10: four distinct addresses written together
    mode = 3'd0;
    for (int i = 0; i < P; i++) setPort(i, 1, 1, 8 + i, 16'hA000 + i);
    step("R10");
    readBack(8, 9, 10, 11, "R10");

    // Sweep: per port action 0 idle, 1 read X, 2 read Y, 3 write X with C,
    // 4 write X with C+1+port, 5 write Y with C; all eight mode codes.
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 1296; n++) begin
        int x, y, c, code;
        x = n % 16;
        y = (n + 5) % 16;
        c = (m << 12) ^ n;
        code = n;
        mode = 3'(m);
        for (int i = 0; i < P; i++) begin
          int s;
          s = code % 6;
          code = code / 6;
          case (s)
            0: setPort(i, 0, 0, 0, 0);
            1: setPort(i, 1, 0, x, 0);
            2: setPort(i, 1, 0, y, 0);
            3: setPort(i, 1, 1, x, c);
            4: setPort(i, 1, 1, x, c + 1 + i);
            default: setPort(i, 1, 1, y, c);
          endcase
        end
        step("");
        readBack(x, y, x, y, "R2");
      end
    end

    summary();
    $finish;
  end

endmodule